// File: doc/BRIEF.md
# Shared-Line Two-Phase Word Write Sequencer

This block writes one data word into a group of magnetic storage cells that all sit on a single shared write line. The line carries a current whose direction sets the polarity of the switch. Each cell has its own gate-voltage select. When a cell is selected, its switching barrier drops, so only selected cells change state while the line current flows. The block has no per-bit write drivers. It writes the word in two phases of opposite polarity. The first phase is a blanket set: every target cell goes to 1. The second phase is a selective clear: only the cells whose data bit is 0 go back to 0.

A request carries the data word and a group mask. The request is taken only while the sequencer is idle. Each phase follows the same steps in order:
1. The gate selects settle for a set number of cycles.
2. The line current is pulsed for a set number of cycles.
3. The current drops, and the selects are held for one more cycle before release.

A turnaround interval between the two phases carries the current-direction reversal. If no masked cell needs clearing, the second phase is skipped. A one-cycle done pulse marks the end of the write.

Top module: `twophase_line_writer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all outputs are low: busy, done, line_en, line_dir and gate_sel.
- R2: A request seen in idle at a clock edge is accepted. busy is high from the following cycle through the done cycle, and line_en is never high unless busy is high.
- R3: Set phase: for SETUP_CYC cycles after acceptance, gate_sel equals the captured mask with line_en low. Then line_en is high for PULSE_CYC cycles with line_dir low (0 = set polarity). gate_sel keeps the same value throughout.
- R4: In the cycle after line_en falls, gate_sel still holds the value it had during the pulse. It is cleared (or changed for the next phase) only after that cycle.
- R5: During the clear pulse, line_dir is high (1 = clear polarity). line_dir changes only when line_en is low in both the cycle before and the cycle of the change. In the TURNAROUND_CYC interval, line_dir goes high from its second cycle onward.
- R6: Clear phase: after turnaround, gate_sel equals mask AND NOT data for SETUP_CYC cycles with line_en low. line_en is then high for PULSE_CYC cycles, and done follows in the next cycle.
- R7: If mask AND NOT data is all zeros, the clear phase is skipped. done comes in the cycle right after the set pulse, which is cycle SETUP_CYC+PULSE_CYC counted from 0 at acceptance, and line_dir stays low.
- R8: done is high for exactly one cycle. In the next cycle the block is idle with all outputs low.
- R9: A request made while busy (including the done cycle) is ignored. It does not change the running sequence and does not start a new one.
- R10: A gate_sel bit whose mask bit is 0 is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Write request, taken only while idle |
| wr_data | input | W | Data word to store |
| grp_mask | input | W | Cells that take part in the write |
| busy | output | 1 | Write in progress, done cycle included |
| done | output | 1 | One-cycle completion pulse |
| line_en | output | 1 | Shared line current enable |
| line_dir | output | 1 | Line current direction, 0 set, 1 clear |
| gate_sel | output | W | Per-cell gate-voltage select |

## Verification
Cycle 0 is the cycle after the edge that accepts a request. Counted from there:
- line_en rises at cycle SETUP_CYC.
- The set-phase selects hold through cycle SETUP_CYC+PULSE_CYC.
- line_dir goes high one cycle later.
- The clear pulse starts at 2*SETUP_CYC+PULSE_CYC+TURNAROUND_CYC.
- done comes at 2*SETUP_CYC+2*PULSE_CYC+TURNAROUND_CYC, or at SETUP_CYC+PULSE_CYC when the clear is skipped.

The bench drives inputs and samples every output on the falling edge. It compares each cycle index against an expected waveform derived from these counts, and checks the done index against a value listed with each stimulus vector. Injected requests during busy must leave that waveform unchanged, and idle must follow.

// File: rtl/twophase_line_writer.sv
module twophase_line_writer #(
  parameter int W              = 8,
  parameter int SETUP_CYC      = 3,
  parameter int PULSE_CYC      = 4,
  parameter int TURNAROUND_CYC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] grp_mask,
  output logic         busy,
  output logic         done,
  output logic         line_en,
  output logic         line_dir,
  output logic [W-1:0] gate_sel
);

  localparam int MAXSP = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAXC  = (MAXSP > TURNAROUND_CYC) ? MAXSP : TURNAROUND_CYC;
  localparam int CW    = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] S_LAST = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] P_LAST = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] T_LAST = CW'(TURNAROUND_CYC - 1);

  typedef enum logic [2:0] {
    IDLE, SET_SETUP, SET_PULSE, TURNAROUND, CLR_SETUP, CLR_PULSE, DONE
  } phase_t;

  phase_t       st;
  logic [CW-1:0] cnt;
  logic [W-1:0] data_q, mask_q, clr_sel;
  logic         dir_q, skip_clr, last;

  assign clr_sel  = mask_q & ~data_q;
  assign skip_clr = ~|clr_sel;

  always_comb begin
    case (st)
      SET_SETUP, CLR_SETUP: last = (cnt == S_LAST);
      SET_PULSE, CLR_PULSE: last = (cnt == P_LAST);
      TURNAROUND:           last = (cnt == T_LAST);
      default:              last = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      cnt    <= '0;
      data_q <= '0;
      mask_q <= '0;
      dir_q  <= 1'b0;
    end else begin
      cnt <= last ? '0 : cnt + CW'(1);
      case (st)
        IDLE: if (req) begin
          st     <= SET_SETUP;
          data_q <= wr_data;
          mask_q <= grp_mask;
        end
        SET_SETUP: if (last) st <= SET_PULSE;
        SET_PULSE: if (last) st <= skip_clr ? DONE : TURNAROUND;
        TURNAROUND: begin
          if (cnt == '0) dir_q <= 1'b1;
          if (last) st <= CLR_SETUP;
        end
        CLR_SETUP: if (last) st <= CLR_PULSE;
        CLR_PULSE: if (last) st <= DONE;
        DONE: begin
          st    <= IDLE;
          dir_q <= 1'b0;
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      SET_SETUP, SET_PULSE: gate_sel = mask_q;
      TURNAROUND:           gate_sel = (cnt == '0) ? mask_q : '0;
      CLR_SETUP, CLR_PULSE: gate_sel = clr_sel;
      DONE:                 gate_sel = skip_clr ? mask_q : clr_sel;
      default:              gate_sel = '0;
    endcase
  end

  assign busy     = (st != IDLE);
  assign done     = (st == DONE);
  assign line_en  = (st == SET_PULSE) || (st == CLR_PULSE);
  assign line_dir = dir_q;

endmodule

// File: rtl/twophase_line_writer_chk.sv
module twophase_line_writer_chk #(
  parameter int W         = 8,
  parameter int SETUP_CYC = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         done,
  input logic         line_en,
  input logic         line_dir,
  input logic [W-1:0] gate_sel,
  input logic [W-1:0] mask_q
);

  logic [W-1:0] sel_prev;
  logic [15:0]  sel_age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_prev <= '0;
      sel_age  <= '0;
    end else begin
      sel_prev <= gate_sel;
      if (gate_sel != sel_prev) sel_age <= '0;
      else if (sel_age != 16'hFFFF) sel_age <= sel_age + 16'd1;
    end
  end

  AST_SEL_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_en) |-> (gate_sel == sel_prev) && (32'(sel_age) >= SETUP_CYC - 1)); // R3
  AST_SEL_HELD_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_en) |-> $stable(gate_sel)); // R4
  AST_DIR_ONLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_dir) |-> !line_en && !$past(line_en)); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R8
  AST_EN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    line_en |-> busy); // R2
  AST_SEL_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_sel & ~mask_q) == '0); // R10

endmodule

bind twophase_line_writer twophase_line_writer_chk #(.W(W), .SETUP_CYC(SETUP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .line_en(line_en),
  .line_dir(line_dir), .gate_sel(gate_sel), .mask_q(mask_q)
);

// File: tb/tb_twophase_line_writer.sv
`timescale 1ns/1ps
module tb_twophase_line_writer;
  localparam int W = 8, S = 3, P = 4, T = 2;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic [W-1:0] wr_data = '0, grp_mask = '0;
  logic busy, done, line_en, line_dir;
  logic [W-1:0] gate_sel;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  twophase_line_writer #(.W(W), .SETUP_CYC(S), .PULSE_CYC(P), .TURNAROUND_CYC(T)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr_data(wr_data), .grp_mask(grp_mask),
    .busy(busy), .done(done), .line_en(line_en), .line_dir(line_dir), .gate_sel(gate_sel));

  // {data, mask, expected done cycle index}
  localparam logic [23:0] VEC [7] = '{
    {8'hA5, 8'hFF, 8'd16},
    {8'hFF, 8'hFF, 8'd7},
    {8'h00, 8'h0F, 8'd16},
    {8'hF0, 8'h0F, 8'd16},
    {8'h0F, 8'hF0, 8'd16},
    {8'h3C, 8'h3C, 8'd7},
    {8'h00, 8'h00, 8'd7}
  };

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic logic [11:0] model(int i, logic [7:0] d, logic [7:0] m);
    logic [7:0] c, s;
    logic b, dn, en, dr;
    c = m & ~d; s = '0; b = 0; dn = 0; en = 0; dr = 0;
    if (i < S) begin b = 1; s = m; end
    else if (i < S + P) begin b = 1; en = 1; s = m; end
    else if (c == 8'h00) begin
      if (i == S + P) begin b = 1; dn = 1; s = m; end
    end
    else if (i == S + P) begin b = 1; s = m; end
    else if (i < S + P + T) begin b = 1; dr = 1; end
    else if (i < 2*S + P + T) begin b = 1; dr = 1; s = c; end
    else if (i < 2*S + 2*P + T) begin b = 1; dr = 1; en = 1; s = c; end
    else if (i == 2*S + 2*P + T) begin b = 1; dr = 1; dn = 1; s = c; end
    return {b, dn, en, dr, s};
  endfunction

  task automatic run_word(logic [7:0] d, logic [7:0] m, int didx, bit inject);
    logic [11:0] e;
    int first_done = -1, mism = 0;
    @(negedge clk);
    req = 1'b1; wr_data = d; grp_mask = m;
    for (int i = 0; i <= didx + 3; i++) begin
      @(negedge clk);
      e = model(i, d, m);
      if ({busy, done, line_en, line_dir, gate_sel} != e) mism++;
      chk(busy == e[11], "R2 busy", 32'(busy), 32'(e[11]));
      chk(done == e[10], "R8 done", 32'(done), 32'(e[10]));
      chk(line_en == e[9], (i < S + P + 1) ? "R3 line_en" : "R6 line_en", 32'(line_en), 32'(e[9]));
      chk(line_dir == e[8], "R5 line_dir", 32'(line_dir), 32'(e[8]));
      chk(gate_sel == e[7:0], (i == S + P) ? "R4 gate_sel" : ((i < S + P) ? "R3 gate_sel" : "R6 gate_sel"),
          32'(gate_sel), 32'(e[7:0]));
      chk((gate_sel & ~m) == 8'h00, "R10 outside mask", 32'(gate_sel), 32'(gate_sel & m));
      if (done && first_done < 0) first_done = i;
      if (inject && (i == 4 || i == 11 || i == didx)) begin
        req = 1'b1; wr_data = ~d; grp_mask = 8'hFF;
      end else begin
        req = 1'b0;
      end
    end
    chk(first_done == didx, ((m & ~d) == 8'h00) ? "R7 done index" : "R6 done index",
        32'(first_done), 32'(didx));
    if (inject) chk(mism == 0, "R9 busy request ignored", 32'(mism), 32'd0);
  endtask

  initial begin
    #1;
    chk({busy, done, line_en, line_dir, gate_sel} == '0, "R1 in reset",
        32'({busy, done, line_en, line_dir, gate_sel}), 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, line_en, line_dir, gate_sel} == '0, "R1 after reset",
        32'({busy, done, line_en, line_dir, gate_sel}), 32'd0);

    for (int k = 0; k < 7; k++)
      run_word(VEC[k][23:16], VEC[k][15:8], int'(VEC[k][7:0]), 1'b0);

    run_word(8'h96, 8'hFF, 16, 1'b1);  // R9
    run_word(8'hFF, 8'h81, 7, 1'b1);   // R9 with skipped clear, R7

    @(negedge clk);
    req = 1'b1; wr_data = 8'h11; grp_mask = 8'hFF;
    @(negedge clk);
    req = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk({busy, done, line_en, line_dir, gate_sel} == '0, "R1 mid-write reset",
        32'({busy, done, line_en, line_dir, gate_sel}), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    run_word(8'h5A, 8'h3F, 16, 1'b0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule